// File: doc/BRIEF.md
# Idle Mode Clock Controller

This block is the power-management unit of a small microcontroller core. It makes two clock-enable strobes from the system clock: one for the CPU and one shared by the peripherals (timers, serial port, SPI, ADC, watchdog and interrupt logic). Software sets an idle-request bit over a simple register bus. From the next cycle the CPU enable is held low while the peripheral enable keeps running. No clock is gated directly; every consumer samples its enable.

While idle, the peripheral enable is slowed by a power-of-two factor taken from a 3-bit select register. Software writes this register before it enters idle. Outside idle the select has no effect, and both enables are high on every cycle. Idle ends in one of two ways. The first is an enabled interrupt: hardware clears the idle bit and the CPU restarts at full rate. The second is the active-low reset.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After reset, idle_o is 0, cpu_en_o and per_en_o are 1, and the power register (address 0x87) and the divider select register (address 0x97) both read 0.
- R2: A bus write to address 0x87 with data bit 0 set and no wake pending sets idle_o and clears cpu_en_o from the next clock edge.
- R3: While idle, cpu_en_o stays 0 on every cycle, and reading address 0x87 returns bit 0 set.
- R4: While idle with a select value n between 1 and 7, per_en_o is 1 on idle cycle k (counted from 0) exactly when k mod 2^n is 0. This gives one pulse every 2, 4 and so on up to 128 system clocks.
- R5: While idle with a select value of 0, per_en_o is 1 on every cycle.
- R6: Outside idle, per_en_o and cpu_en_o are 1 on every cycle, whatever the select value.
- R7: If wake_i is high during an idle cycle, idle is left at the next clock edge. From that edge cpu_en_o is 1, idle_o is 0 and bit 0 of address 0x87 reads 0.
- R8: A write that sets the idle bit while wake_i is high does not enter idle: idle_o stays 0 and cpu_en_o stays 1.
- R9: The select register holds data bits 2:0 written to address 0x97. Bits 7:3 read as 0 and writes to them are ignored.
- R10: The select value is kept across idle periods. Each idle period starts its divider phase again, so its first cycle carries a peripheral pulse.
- R11: Asserting rst_ni during idle ends idle at once and returns the select register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| wake_i | input | 1 | Interrupt pending and enabled |
| idle_o | output | 1 | Idle state |
| cpu_en_o | output | 1 | CPU clock enable |
| per_en_o | output | 1 | Peripheral clock enable |

## Verification
The bench builds the block with its default parameters: a 3-bit select, a 7-bit divider counter and the two register addresses 0x87 and 0x97. With these values every divide ratio from 1 to 128 is reachable. Each ratio is checked for pulse position over a 256-cycle idle window, which covers at least two full periods of the slowest setting. Wake and re-entry cases confirm that the divider phase restarts on each idle entry.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;
  parameter int unsigned REG_AW = 8;
  parameter int unsigned REG_DW = 8;

  typedef logic [REG_AW-1:0] reg_addr_t;
  typedef logic [REG_DW-1:0] reg_data_t;

  localparam reg_addr_t PWR_ADDR_DEF = 8'h87;
  localparam reg_addr_t DIV_ADDR_DEF = 8'h97;
  localparam int unsigned IDLE_BIT = 0;
endpackage

// File: rtl/idle_clk_regs.sv
module idle_clk_regs
  import idle_clk_pkg::*;
#(
  parameter int unsigned DIV_W    = 3,
  parameter reg_addr_t   PWR_ADDR = PWR_ADDR_DEF,
  parameter reg_addr_t   DIV_ADDR = DIV_ADDR_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_addr_t        addr_i,
  input  reg_data_t        wdata_i,
  input  logic             wake_i,
  output reg_data_t        rdata_o,
  output logic             idle_o,
  output logic [DIV_W-1:0] sel_o
);

  logic             idle_q;
  logic [DIV_W-1:0] sel_q;
  logic             pwr_hit, div_hit;

  assign pwr_hit = we_i && (addr_i == PWR_ADDR);
  assign div_hit = we_i && (addr_i == DIV_ADDR);

  // wake has priority over a set request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idle_q <= 1'b0;
    else if (wake_i)  idle_q <= 1'b0;
    else if (pwr_hit) idle_q <= wdata_i[IDLE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (div_hit) sel_q <= wdata_i[DIV_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == PWR_ADDR)      rdata_o[IDLE_BIT]  = idle_q;
    else if (addr_i == DIV_ADDR) rdata_o[DIV_W-1:0] = sel_q;
  end

  assign idle_o = idle_q;
  assign sel_o  = sel_q;

  // R7
  wake_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q && wake_i |=> !idle_q);

  // R8
  pend_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_hit && wdata_i[IDLE_BIT] && wake_i |=> !idle_q);

  // R9
  sel_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DIV_ADDR) |-> (rdata_o[REG_DW-1:DIV_W] == '0));

  // R10
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_hit |=> $stable(sel_q));

endmodule

// File: rtl/idle_clk_div.sv
module idle_clk_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic [DIV_W-1:0] sel_i,
  output logic             per_en_o
);

  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // low sel bits of the counter set; all zero marks a pulse
  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!idle_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign per_en_o = !idle_i || ((cnt_q & mask) == '0);

  // R10
  first_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_i) |-> per_en_o);

  // R4
  pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && per_en_o && (sel_i != '0) |=> !idle_i || !per_en_o || !$stable(sel_i));

  // R5
  full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> per_en_o);

endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl
  import idle_clk_pkg::*;
#(
  parameter int unsigned DIV_W    = 3,
  parameter reg_addr_t   PWR_ADDR = PWR_ADDR_DEF,
  parameter reg_addr_t   DIV_ADDR = DIV_ADDR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              wake_i,
  output logic              idle_o,
  output logic              cpu_en_o,
  output logic              per_en_o
);

  logic             idle;
  logic [DIV_W-1:0] sel;

  idle_clk_regs #(
    .DIV_W   (DIV_W),
    .PWR_ADDR(PWR_ADDR),
    .DIV_ADDR(DIV_ADDR)
  ) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .wake_i (wake_i),
    .rdata_o(reg_rdata_o),
    .idle_o (idle),
    .sel_o  (sel)
  );

  idle_clk_div #(
    .DIV_W(DIV_W)
  ) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (idle),
    .sel_i   (sel),
    .per_en_o(per_en_o)
  );

  assign idle_o   = idle;
  assign cpu_en_o = !idle;

  // R2
  enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_addr_i == PWR_ADDR) && reg_wdata_i[IDLE_BIT] && !wake_i
    |=> idle_o && !cpu_en_o);

  // R6
  run_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |-> cpu_en_o && per_en_o);

endmodule

// File: tb/test_idle_clk_ctrl.sv
module test_idle_clk_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] PWR = 8'h87;
  localparam logic [7:0] DIV = 8'h97;
  localparam int WIN = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wake = 1'b0;
  logic       idle, cpu_en, per_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_clk_ctrl i_idle_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_i(wake),
    .idle_o(idle), .cpu_en_o(cpu_en), .per_en_o(per_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(idle == 1'b0, "R1 idle", idle, 0);
    chk(cpu_en == 1'b1, "R1 cpu_en", cpu_en, 1);
    chk(per_en == 1'b1, "R1 per_en", per_en, 1);
    rd(PWR, d); chk(d == 8'h00, "R1 pwr read", d, 0);
    rd(DIV, d); chk(d == 8'h00, "R1 div read", d, 0);
  endtask

  task automatic t_run_rate();
    int hi_c = 0, hi_p = 0;
    wr(DIV, 8'h05);
    for (int k = 0; k < 20; k++) begin
      if (cpu_en) hi_c++;
      if (per_en) hi_p++;
      @(negedge clk);
    end
    chk(hi_c == 20, "R6 cpu_en run", hi_c, 20);
    chk(hi_p == 20, "R6 per_en run", hi_p, 20);
  endtask

  task automatic t_sel_field();
    logic [7:0] d;
    wr(DIV, 8'hFA);
    rd(DIV, d); chk(d == 8'h02, "R9 sel masked", d, 2);
    wr(DIV, 8'hF8);
    rd(DIV, d); chk(d == 8'h00, "R9 hi bits ignored", d, 0);
  endtask

  // enter idle with select n, check pulse pattern, then wake
  task automatic t_ratio(input int n);
    logic [7:0] d;
    int bad = 0, cpu_hi = 0;
    wr(DIV, 8'(n));
    wr(PWR, 8'h01);
    chk(idle == 1'b1, "R2 idle entered", idle, 1);
    rd(PWR, d); chk(d[0] == 1'b1, "R3 pwr bit read", d[0], 1);
    for (int k = 0; k < WIN; k++) begin
      if (per_en != ((k % (1 << n)) == 0)) bad++;
      if (cpu_en) cpu_hi++;
      @(negedge clk);
    end
    chk(bad == 0, (n == 0) ? "R5 full rate" : "R4 pulse pattern", bad, 0);
    chk(cpu_hi == 0, "R3 cpu held", cpu_hi, 0);
    wake = 1'b1;
    #1;
    chk(cpu_en == 1'b0, "R7 still idle before edge", cpu_en, 0);
    @(negedge clk);
    wake = 1'b0;
    chk(cpu_en == 1'b1 && idle == 1'b0, "R7 wake", {idle, cpu_en}, 1);
    rd(PWR, d); chk(d[0] == 1'b0, "R7 bit cleared", d[0], 0);
  endtask

  task automatic t_reentry();
    logic [7:0] d;
    int bad = 0;
    wr(DIV, 8'h03);
    wr(PWR, 8'h01);
    repeat (5) @(negedge clk);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    rd(DIV, d); chk(d == 8'h03, "R10 sel kept", d, 3);
    wr(PWR, 8'h01);
    for (int k = 0; k < 32; k++) begin
      if (per_en != ((k % 8) == 0)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 phase restart", bad, 0);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
  endtask

  task automatic t_pending();
    wake = 1'b1;
    wr(PWR, 8'h01);
    chk(idle == 1'b0 && cpu_en == 1'b1, "R8 pending blocks", {idle, cpu_en}, 1);
    @(negedge clk);
    chk(idle == 1'b0, "R8 stays out", idle, 0);
    wake = 1'b0;
  endtask

  task automatic t_reset_wake();
    logic [7:0] d;
    wr(DIV, 8'h04);
    wr(PWR, 8'h01);
    chk(idle == 1'b1, "R11 idle before reset", idle, 1);
    #2 rst_n = 1'b0;
    #1;
    chk(idle == 1'b0 && cpu_en == 1'b1, "R11 reset ends idle", {idle, cpu_en}, 1);
    @(negedge clk);
    rst_n = 1'b1;
    rd(DIV, d); chk(d == 8'h00, "R11 sel reset", d, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_rate();
    t_sel_field();
    for (int n = 0; n < 8; n++) t_ratio(n);
    t_reentry();
    t_pending();
    t_reset_wake();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end
endmodule